// File: doc/BRIEF.md
# Circular Window Limit Calculator

This block decides how far a trace producer may write next into a circular buffer that it shares with a consumer. It takes the producer's running head index, the number of free bytes ahead of it, a wakeup index, the buffer size in pages and the write alignment. From these it returns three results: the offset at which the producer must stop (the limit), the number of filler bytes to place in front of the head, and a truncation flag. The filler bytes are not written by this block. Each pad that is reported moves the head forward by that many bytes and takes the same amount off the free size.

The calculation runs over several cycles and reuses a single window evaluator. It first pads the head up to the next aligned offset. It then forms a page-aligned limit from the tail and the wakeup point. If the window it finds is too small to be useful, it pads that window away and runs the calculation one more time. In snapshot mode the whole buffer is handed out as it is.

A request is taken on a valid/ready handshake. `req_ready` is high only while the block is idle, so the requester is held off for as long as a calculation is in progress. The result is presented with `res_valid` and stays stable until `res_ready` is seen high. This lets the consumer of the result stall the block for any number of cycles.

Top module: `cwl_top`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the result has been consumed. `res_valid` and every result field stay unchanged until `res_ready` is high.
- R2: The head, tail (head + free size) and wakeup indices are reduced modulo the buffer size in bytes (`num_pages` × 4096). `head_off` reports the reduced head after all padding has been applied.
- R3: If the head offset is not a multiple of 2^`align_log2`, the block pads up to the next multiple. This pad is capped at the free size, and it advances the head.
- R4: If the free size is zero once alignment is done, the result is limit 0 with `trunc` = 1.
- R5: If the head offset is below the tail offset, the limit is the tail offset rounded down to a 4096-byte page. Otherwise the limit is the buffer size.
- R6: If the wakeup index is below head + free size and the wakeup offset is not below the head offset, the limit becomes the smaller of the current limit and the wakeup offset rounded up to a page. A wakeup whose offset lies below the head offset has no effect.
- R7: If the limit is not above the head offset, the whole free size is padded, `trunc` = 1 and the limit is 0.
- R8: On the first pass, if the limit is above the head by fewer than 64 bytes, the block pads that gap and runs the calculation again, alignment step included. The result of the second pass is final.
- R9: If `num_pages` is below 2, the request is rejected with `cfg_err` = 1, limit 0, pad 0 and `trunc` = 0.
- R10: In snapshot mode the limit is the full buffer size, and the result carries no pad and no truncation.
- R11: Every limit is a multiple of 4096. A result that is neither truncated nor rejected has a limit strictly above `head_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| head_idx | input | 32 | Running producer head index |
| free_size | input | 32 | Writable bytes ahead of the head |
| wake_idx | input | 32 | Running wakeup index |
| num_pages | input | 8 | Buffer size in 4096-byte pages |
| align_log2 | input | 4 | Write alignment as a power of two |
| snapshot | input | 1 | Snapshot mode select |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer accepts |
| limit_off | output | 32 | Limit offset to program, 0 when none |
| pad_len | output | 32 | Total filler bytes placed before the head |
| head_off | output | 32 | Final head offset within the buffer |
| trunc | output | 1 | No usable window was found |
| cfg_err | output | 1 | Buffer configuration rejected |

## Verification
The hardest path to reach is the second pass. The first window must land above the head yet within 64 bytes of it, and the retry must then produce a wider window from the advanced head. The stimulus sets the head 48 bytes below a page boundary and places a wakeup just past the head, so the first limit clips to that boundary. After the gap is padded, the head sits above the wakeup offset, so the wakeup no longer clips and the tail sets the final limit. Separate directed cases cover an alignment pad that uses up all the free space, and a tail that shares a page with the head.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_EVAL,
    ST_DONE
  } cwl_state_e;

  // Number of offsets reduced modulo the buffer size: head, tail, wakeup
  localparam int unsigned N_OFFS = 3;
endpackage

// File: rtl/cwl_wrap.sv
// Reduces a running index to an offset inside the buffer
module cwl_wrap #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] span,
  output logic [W-1:0] off
);
  always_comb begin
    if (span == '0) off = '0;
    else            off = idx % span;
  end
endmodule

// File: rtl/cwl_window.sv
// One pass of the window evaluation: tail bound, then wakeup clip
module cwl_window #(
  parameter int unsigned W          = 32,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic [W-1:0] hoff,
  input  logic [W-1:0] toff,
  input  logic [W-1:0] woff,
  input  logic         wake_live,
  input  logic [W-1:0] bsz,
  output logic [W-1:0] limit
);
  localparam logic [W-1:0] PMASK = (W'(1) << PAGE_SHIFT) - W'(1);

  logic [W-1:0] tail_dn, wake_up, bound;

  always_comb begin
    tail_dn = toff & ~PMASK;
    wake_up = (woff + PMASK) & ~PMASK;
    bound   = (hoff < toff) ? tail_dn : bsz;
    if (wake_live && (woff >= hoff) && (wake_up < bound)) limit = wake_up;
    else                                                    limit = bound;
  end
endmodule

// File: rtl/cwl_top.sv
module cwl_top #(
  parameter int unsigned IDX_W      = 32,
  parameter int unsigned PG_W       = 8,
  parameter int unsigned AL_W       = 4,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned MIN_WIN    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] free_size,
  input  logic [IDX_W-1:0] wake_idx,
  input  logic [PG_W-1:0]  num_pages,
  input  logic [AL_W-1:0]  align_log2,
  input  logic             snapshot,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [IDX_W-1:0] limit_off,
  output logic [IDX_W-1:0] pad_len,
  output logic [IDX_W-1:0] head_off,
  output logic             trunc,
  output logic             cfg_err
);
  import cwl_pkg::*;

  localparam logic [IDX_W-1:0] MIN_GAP = IDX_W'(MIN_WIN);

  cwl_state_e       st;
  logic [IDX_W-1:0] head_q, size_q, wake_q, bsz_q, amask_q;
  logic [IDX_W-1:0] pad_q, limit_q;
  logic             snap_q, second_q, trunc_q, rej_q;

  logic [IDX_W-1:0] idx_a [N_OFFS];
  logic [IDX_W-1:0] off_a [N_OFFS];
  logic [IDX_W-1:0] hoff, toff, woff, cand, delta, gap, bsz_in;
  logic             wake_live;

  assign idx_a[0] = head_q;
  assign idx_a[1] = head_q + size_q;
  assign idx_a[2] = wake_q;

  for (genvar g = 0; g < N_OFFS; g++) begin : g_wrap
    cwl_wrap #(.W(IDX_W)) u_wrap (
      .idx  (idx_a[g]),
      .span (bsz_q),
      .off  (off_a[g])
    );
  end

  assign hoff      = off_a[0];
  assign toff      = off_a[1];
  assign woff      = off_a[2];
  assign wake_live = wake_q < (head_q + size_q);

  cwl_window #(.W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)) u_win (
    .hoff      (hoff),
    .toff      (toff),
    .woff      (woff),
    .wake_live (wake_live),
    .bsz       (bsz_q),
    .limit     (cand)
  );

  always_comb begin
    delta = (IDX_W'(0) - hoff) & amask_q;
    if (delta > size_q) delta = size_q;
    gap = cand - hoff;
  end

  assign bsz_in = IDX_W'(num_pages) << PAGE_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      head_q   <= '0;
      size_q   <= '0;
      wake_q   <= '0;
      bsz_q    <= '0;
      amask_q  <= '0;
      pad_q    <= '0;
      limit_q  <= '0;
      snap_q   <= 1'b0;
      second_q <= 1'b0;
      trunc_q  <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          head_q   <= head_idx;
          size_q   <= free_size;
          wake_q   <= wake_idx;
          bsz_q    <= bsz_in;
          amask_q  <= (IDX_W'(1) << align_log2) - IDX_W'(1);
          snap_q   <= snapshot;
          pad_q    <= '0;
          limit_q  <= '0;
          second_q <= 1'b0;
          trunc_q  <= 1'b0;
          rej_q    <= 1'b0;
          if (num_pages < PG_W'(2)) begin
            rej_q <= 1'b1;
            st    <= ST_DONE;
          end else if (snapshot) begin
            limit_q <= bsz_in;
            st      <= ST_DONE;
          end else begin
            st <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          head_q <= head_q + delta;
          size_q <= size_q - delta;
          pad_q  <= pad_q + delta;
          st     <= ST_EVAL;
        end
        ST_EVAL: begin
          if (size_q == '0) begin
            trunc_q <= 1'b1;
            limit_q <= '0;
            st      <= ST_DONE;
          end else if (cand > hoff) begin
            if (!second_q && gap < MIN_GAP) begin
              head_q   <= head_q + gap;
              size_q   <= size_q - gap;
              pad_q    <= pad_q + gap;
              second_q <= 1'b1;
              st       <= ST_ALIGN;
            end else begin
              limit_q <= cand;
              st      <= ST_DONE;
            end
          end else begin
            head_q  <= head_q + size_q;
            pad_q   <= pad_q + size_q;
            size_q  <= '0;
            trunc_q <= 1'b1;
            limit_q <= '0;
            st      <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign res_valid = (st == ST_DONE);
  assign limit_off = limit_q;
  assign pad_len   = pad_q;
  assign head_off  = hoff;
  assign trunc     = trunc_q;
  assign cfg_err   = rej_q;

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(limit_off) && $stable(pad_len)
      && $stable(trunc) && $stable(head_off)); // R1
  AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> limit_off[PAGE_SHIFT-1:0] == '0); // R11
  AST_LIMIT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !trunc && !cfg_err |-> limit_off > head_off); // R11
  AST_TRUNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && trunc |-> limit_off == '0); // R4
  AST_SNAP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && snap_q && !cfg_err |-> pad_len == '0 && !trunc && limit_off == bsz_q); // R10
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cfg_err |-> limit_off == '0 && pad_len == '0 && !trunc); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1
endmodule

// File: tb/sim_cwl_top.sv
module sim_cwl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] head_idx = '0, free_size = '0, wake_idx = '0;
  logic [7:0]  num_pages = 8'd4;
  logic [3:0]  align_log2 = 4'd3;
  logic        snapshot = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] limit_off, pad_len, head_off;
  logic        trunc, cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cwl_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .head_idx(head_idx), .free_size(free_size), .wake_idx(wake_idx),
    .num_pages(num_pages), .align_log2(align_log2), .snapshot(snapshot),
    .res_valid(res_valid), .res_ready(res_ready), .limit_off(limit_off),
    .pad_len(pad_len), .head_off(head_off), .trunc(trunc), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Issue one request and wait for the result (left pending, not consumed)
  task automatic issue(input logic [31:0] h, input logic [31:0] s, input logic [31:0] w,
                       input logic [7:0] np, input logic [3:0] al, input logic sn);
    @(negedge clk);
    head_idx = h; free_size = s; wake_idx = w;
    num_pages = np; align_log2 = al; snapshot = sn;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (res_valid) break;
    end
  endtask

  task automatic consume();
    @(negedge clk);
    res_ready = 1'b1;
    @(posedge clk);
    #1 res_ready = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [31:0] lim, input logic [31:0] pad,
                            input logic [31:0] hoff, input logic tr);
    check({tag, " res_valid"}, {31'd0, res_valid}, 32'd1);
    check({tag, " limit"}, limit_off, lim);
    check({tag, " pad"}, pad_len, pad);
    check({tag, " head_off"}, head_off, hoff);
    check({tag, " trunc"}, {31'd0, trunc}, {31'd0, tr});
    check({tag, " R11 page"}, {20'd0, limit_off[11:0]}, 32'd0);
    consume();
  endtask

  task automatic t_reset();
    check("R1 reset res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_tail_bound();
    issue(32'h1000, 32'h2800, 32'h3800, 8'd4, 4'd3, 1'b0);
    expect_res("R5 head<tail", 32'h3000, 32'd0, 32'h1000, 1'b0);
  endtask

  task automatic t_wrap_end();
    issue(32'hB000, 32'h2000, 32'hD000, 8'd4, 4'd3, 1'b0);
    expect_res("R5 R2 tail wrapped", 32'h4000, 32'd0, 32'h3000, 1'b0);
  endtask

  task automatic t_align();
    issue(32'h1005, 32'h2000, 32'h3005, 8'd4, 4'd4, 1'b0);
    expect_res("R3 align pad", 32'h3000, 32'd11, 32'h1010, 1'b0);
  endtask

  task automatic t_align_cap();
    issue(32'h1005, 32'd5, 32'h100A, 8'd4, 4'd4, 1'b0);
    expect_res("R3 R4 pad capped", 32'd0, 32'd5, 32'h100A, 1'b1);
  endtask

  task automatic t_zero();
    issue(32'h0800, 32'd0, 32'h0800, 8'd4, 4'd3, 1'b0);
    expect_res("R4 zero free", 32'd0, 32'd0, 32'h0800, 1'b1);
  endtask

  task automatic t_wake_clip();
    issue(32'h1000, 32'h2800, 32'h1900, 8'd4, 4'd3, 1'b0);
    expect_res("R6 wake clip", 32'h2000, 32'd0, 32'h1000, 1'b0);
  endtask

  task automatic t_wake_behind();
    issue(32'h1000, 32'h2800, 32'h0800, 8'd4, 4'd3, 1'b0);
    expect_res("R6 wake behind ignored", 32'h3000, 32'd0, 32'h1000, 1'b0);
  endtask

  task automatic t_no_room();
    issue(32'h1100, 32'h0E00, 32'h1F00, 8'd4, 4'd3, 1'b0);
    expect_res("R7 no room", 32'd0, 32'h0E00, 32'h1F00, 1'b1);
  endtask

  task automatic t_small_window();
    issue(32'h0FD0, 32'h3000, 32'h0FE0, 8'd4, 4'd3, 1'b0);
    expect_res("R8 small window", 32'h3000, 32'd48, 32'h1000, 1'b0);
  endtask

  task automatic t_reject();
    issue(32'h0, 32'h800, 32'h800, 8'd1, 4'd3, 1'b0);
    check("R9 cfg_err", {31'd0, cfg_err}, 32'd1);
    expect_res("R9 reject", 32'd0, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_snapshot();
    issue(32'h1005, 32'd0, 32'h0, 8'd4, 4'd4, 1'b1);
    check("R10 cfg_err", {31'd0, cfg_err}, 32'd0);
    expect_res("R10 snapshot", 32'h4000, 32'd0, 32'h1005, 1'b0);
  endtask

  task automatic t_odd_pages();
    issue(32'h4000, 32'h1000, 32'h5000, 8'd3, 4'd3, 1'b0);
    expect_res("R2 three pages", 32'h2000, 32'd0, 32'h1000, 1'b0);
  endtask

  task automatic t_backpressure();
    issue(32'h1000, 32'h2800, 32'h3800, 8'd4, 4'd3, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 held valid", {31'd0, res_valid}, 32'd1);
      check("R1 busy ready", {31'd0, req_ready}, 32'd0);
      check("R1 held limit", limit_off, 32'h3000);
    end
    consume();
    @(negedge clk);
    check("R1 released valid", {31'd0, res_valid}, 32'd0);
    check("R1 released ready", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tail_bound();
    t_wrap_end();
    t_align();
    t_align_cap();
    t_zero();
    t_wake_clip();
    t_wake_behind();
    t_no_room();
    t_small_window();
    t_reject();
    t_snapshot();
    t_odd_pages();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule